// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running up-counter with a programmable clock divider and four compare slots. A prescale counter steps on every clock. Each time it reaches a programmed limit the main count advances by one, and the prescale counter starts again from zero. Every compare slot is checked against the main count on each advance. A per-slot action field decides what an equal compare does: it can latch an interrupt flag, return the count to zero, halt the timer, or any mix of the three.

As an alternative to the divided clock, the count can be driven by rising edges on one of two external capture inputs. Each input first passes through a two-stage synchroniser.

Software drives the block through a word-addressed register port with a combinational read path. A small run-state machine decides whether the count is idle, counting or held clear. It has three states: `RUN_IDLE`, `RUN_COUNT` and `RUN_CLEAR`.

The state machine follows these transitions:
- A write to the control word with the clear bit set moves any state to `RUN_CLEAR`.
- A write with clear low and enable high moves any state to `RUN_COUNT`.
- A write with both bits low moves any state to `RUN_IDLE`.
- In `RUN_COUNT`, a halt action from a compare slot moves to `RUN_IDLE`. A control write in the same cycle takes priority over the halt.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, the state is `RUN_IDLE` and `irq` is low.
- R2: The register map uses word indices. CTRL is 0 and COUNT is 1 (read only). PLIM is 2 and PCNT is 3 (read only). ACT is 4, FLAGS is 5 and SRC is 6. CMP0..CMP3 are 8..11.
- R3: In timer mode (SRC bits 1:0 equal 00) while counting, COUNT advances once every PLIM+1 clocks, and PCNT reads the clocks elapsed since the last advance (0..PLIM).
- R4: COUNT wraps from all ones to zero and sets no flag unless a compare slot holding the all-ones value has its flag action enabled.
- R5: ACT holds 3 bits per slot n at bits 3n+2..3n. When COUNT equals CMPn at an advance and bit 3n is set, FLAGS bit n becomes 1.
- R6: With bit 3n+1 set, a match returns COUNT to zero in place of advancing, so the count cycles through CMPn+1 values.
- R7: With bit 3n+2 set, a match leaves COUNT at CMPn and the timer stops. CTRL bit 0 then reads 0. If bit 3n+1 is also set, COUNT reads zero.
- R8: Writing a 1 to a FLAGS bit clears it, and writing a 0 leaves it unchanged. `irq` is high whenever any flag is set.
- R9: CTRL bit 0 enables counting and bit 1 holds COUNT and PCNT at zero. CTRL reads back {clear, enable} from the state: 2 in `RUN_CLEAR`, 1 in `RUN_COUNT`, 0 in `RUN_IDLE`. In `RUN_IDLE` COUNT holds its value.
- R10: When SRC bits 1:0 are not 00, each rising edge on the capture input chosen by SRC bits 3:2 advances COUNT once. Code 00 picks input 0 and 01 picks input 1. The other input is ignored and PCNT stays 0.
- R11: In edge mode, select codes 10 and 11 pick no input, and COUNT does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Register word index |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cap_in | input | NCAP | Asynchronous capture inputs |
| irq | output | 1 | OR of all pending match flags |

## Verification
The bench builds the block with an 8-bit count (TW=8) and the default four compare slots. This makes the wrap from all ones to zero reachable within a few hundred clocks, so the wrap can be checked both with and without an all-ones compare. Random limits, compare values and run lengths check the divide ratio, the clear-on-match period and the halt-on-match hold. Directed sequences cover the flag clear semantics, both capture inputs and the reserved select codes.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam int DW    = 32;
    localparam int ACT_W = 3;

    localparam int A_CTRL  = 0;
    localparam int A_COUNT = 1;
    localparam int A_PLIM  = 2;
    localparam int A_PCNT  = 3;
    localparam int A_ACT   = 4;
    localparam int A_FLAGS = 5;
    localparam int A_SRC   = 6;
    localparam int A_CMP0  = 8;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_COUNT = 2'd1,
        RUN_CLEAR = 2'd2
    } run_state_t;

    typedef struct packed {
        logic halt;
        logic zero;
        logic flag;
    } act_t;
endpackage

// File: rtl/mtimer_runfsm.sv
module mtimer_runfsm
    import mtimer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic cmd_en,
    input  logic cmd_clr,
    input  logic halt_hit,
    output logic run,
    output logic clr
);
    run_state_t state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RUN_IDLE;
        else        state <= nxt;
    end

    // next state: a software write always wins over a halt action
    always_comb begin
        nxt = state;
        unique case (state)
            RUN_IDLE: begin
                if (cmd_we) nxt = cmd_clr ? RUN_CLEAR : (cmd_en ? RUN_COUNT : RUN_IDLE);
            end
            RUN_COUNT: begin
                if (cmd_we)        nxt = cmd_clr ? RUN_CLEAR : (cmd_en ? RUN_COUNT : RUN_IDLE);
                else if (halt_hit) nxt = RUN_IDLE;
            end
            RUN_CLEAR: begin
                if (cmd_we) nxt = cmd_clr ? RUN_CLEAR : (cmd_en ? RUN_COUNT : RUN_IDLE);
            end
            default: nxt = RUN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run = 1'b0;
        clr = 1'b0;
        unique case (state)
            RUN_IDLE:  ;
            RUN_COUNT: run = 1'b1;
            RUN_CLEAR: clr = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/mtimer_edge.sv
module mtimer_edge #(
    parameter int NIN = 2,
    parameter int SW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] cap_in,
    input  logic [SW-1:0]  sel,
    output logic           pulse
);
    logic [NIN-1:0] s1, s2, s3;
    logic [NIN-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= cap_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    generate
        for (genvar i = 0; i < NIN; i++) begin : g_rise
            assign rise[i] = s2[i] & ~s3[i];
        end
    endgenerate

    // codes beyond the input count select nothing
    always_comb begin
        pulse = 1'b0;
        for (int i = 0; i < NIN; i++) begin
            if (sel == SW'(i)) pulse = rise[i];
        end
    end
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core #(
    parameter int TW = 32,
    parameter int NM = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 clr,
    input  logic                 ext_mode,
    input  logic                 ext_pulse,
    input  logic [TW-1:0]        plim,
    input  logic [NM-1:0][TW-1:0] cmp,
    input  logic [NM-1:0]        zero_mask,
    input  logic [NM-1:0]        halt_mask,
    output logic [TW-1:0]        tc,
    output logic [TW-1:0]        pc,
    output logic [NM-1:0]        match_ev,
    output logic                 halt_hit
);
    logic pre_done;
    logic tick;
    logic zero_any;

    assign pre_done = (pc >= plim);
    assign tick     = run & (ext_mode ? ext_pulse : pre_done);

    generate
        for (genvar n = 0; n < NM; n++) begin : g_cmp
            assign match_ev[n] = tick & (tc == cmp[n]);
        end
    endgenerate

    assign zero_any = |(match_ev & zero_mask);
    assign halt_hit = |(match_ev & halt_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc <= '0;
            pc <= '0;
        end else if (clr) begin
            tc <= '0;
            pc <= '0;
        end else if (run) begin
            if (ext_mode)      pc <= '0;
            else if (pre_done) pc <= '0;
            else               pc <= pc + TW'(1);
            if (tick) begin
                if (zero_any)      tc <= '0;
                else if (!halt_hit) tc <= tc + TW'(1);
            end
        end
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import mtimer_pkg::*;
#(
    parameter int TW   = 32,
    parameter int NM   = 4,
    parameter int AW   = 4,
    parameter int NCAP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_we,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NCAP-1:0] cap_in,
    output logic            irq
);
    localparam int ACTBITS = ACT_W * NM;
    localparam int SRCW    = 4;
    localparam int SELW    = 2;

    logic                  run, clr, halt_hit, ext_mode, ext_pulse;
    logic                  ctrl_we, plim_we, act_we, flag_we, src_we;
    logic [TW-1:0]         plim, tc, pc;
    logic [ACTBITS-1:0]    act_bits;
    act_t [NM-1:0]         act;
    logic [NM-1:0][TW-1:0] cmp;
    logic [NM-1:0]         flags, match_ev, irq_mask, zero_mask, halt_mask;
    logic [SRCW-1:0]       src;

    assign ctrl_we = reg_we && (reg_addr == AW'(A_CTRL));
    assign plim_we = reg_we && (reg_addr == AW'(A_PLIM));
    assign act_we  = reg_we && (reg_addr == AW'(A_ACT));
    assign flag_we = reg_we && (reg_addr == AW'(A_FLAGS));
    assign src_we  = reg_we && (reg_addr == AW'(A_SRC));

    assign act = act_bits;

    generate
        for (genvar n = 0; n < NM; n++) begin : g_mask
            assign irq_mask[n]  = act[n].flag;
            assign zero_mask[n] = act[n].zero;
            assign halt_mask[n] = act[n].halt;
        end
    endgenerate

    assign ext_mode = |src[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plim     <= '0;
            act_bits <= '0;
            src      <= '0;
            flags    <= '0;
            cmp      <= '0;
        end else begin
            if (plim_we) plim     <= reg_wdata[TW-1:0];
            if (act_we)  act_bits <= reg_wdata[ACTBITS-1:0];
            if (src_we)  src      <= reg_wdata[SRCW-1:0];
            flags <= (flags & ~(flag_we ? reg_wdata[NM-1:0] : {NM{1'b0}}))
                   | (match_ev & irq_mask);
            for (int n = 0; n < NM; n++) begin
                if (reg_we && (reg_addr == AW'(A_CMP0 + n))) cmp[n] <= reg_wdata[TW-1:0];
            end
        end
    end

    assign irq = |flags;

    mtimer_runfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (ctrl_we),
        .cmd_en   (reg_wdata[0]),
        .cmd_clr  (reg_wdata[1]),
        .halt_hit (halt_hit),
        .run      (run),
        .clr      (clr)
    );

    mtimer_edge #(.NIN(NCAP), .SW(SELW)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_in (cap_in),
        .sel    (src[3:2]),
        .pulse  (ext_pulse)
    );

    mtimer_core #(.TW(TW), .NM(NM)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clr       (clr),
        .ext_mode  (ext_mode),
        .ext_pulse (ext_pulse),
        .plim      (plim),
        .cmp       (cmp),
        .zero_mask (zero_mask),
        .halt_mask (halt_mask),
        .tc        (tc),
        .pc        (pc),
        .match_ev  (match_ev),
        .halt_hit  (halt_hit)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(A_CTRL):  reg_rdata[1:0]         = {clr, run};
            AW'(A_COUNT): reg_rdata[TW-1:0]      = tc;
            AW'(A_PLIM):  reg_rdata[TW-1:0]      = plim;
            AW'(A_PCNT):  reg_rdata[TW-1:0]      = pc;
            AW'(A_ACT):   reg_rdata[ACTBITS-1:0] = act_bits;
            AW'(A_FLAGS): reg_rdata[NM-1:0]      = flags;
            AW'(A_SRC):   reg_rdata[SRCW-1:0]    = src;
            default:      ;
        endcase
        for (int n = 0; n < NM; n++) begin
            if (reg_addr == AW'(A_CMP0 + n)) reg_rdata[TW-1:0] = cmp[n];
        end
    end
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
    parameter int TW = 32,
    parameter int NM = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          clr,
    input logic          ctrl_we,
    input logic          halt_hit,
    input logic [TW-1:0] tc,
    input logic [TW-1:0] pc,
    input logic [NM-1:0] match_ev,
    input logic [NM-1:0] irq_mask,
    input logic [NM-1:0] flags
);
    // R3
    tc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tc) |-> (tc == $past(tc) + TW'(1) || tc == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(tc));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tc == '0 && pc == '0));

    // R7
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_hit && !ctrl_we) |=> !run);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(match_ev & irq_mask)) |=>
        ((flags & $past(match_ev & irq_mask)) == $past(match_ev & irq_mask)));

    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ev == '0) |=> ((flags & ~$past(flags)) == '0));
endmodule

bind match_timer mtimer_chk #(.TW(TW), .NM(NM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clr      (clr),
    .ctrl_we  (ctrl_we),
    .halt_hit (halt_hit),
    .tc       (tc),
    .pc       (pc),
    .match_ev (match_ev),
    .irq_mask (irq_mask),
    .flags    (flags)
);

// File: tb/match_timer_test.sv
module match_timer_test;
    localparam int TW = 8;
    localparam int NM = 4;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  cap_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    match_timer #(.TW(TW), .NM(NM), .AW(AW), .NCAP(2)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic int ticks_of(int k, int p);
        return k / (p + 1);
    endfunction

    function automatic int cyc_of(int t, int m);
        return t % (m + 1);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        reg_wdata = d;
        reg_we = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        reg_addr = AW'(a);
        #1 v = reg_rdata;
    endtask

    task automatic restart();
        wr(0, 32'd2);
        wr(0, 32'd1);
    endtask

    task automatic pulse(int i);
        @(negedge clk);
        cap_in[i] = 1'b1;
        repeat (3) @(negedge clk);
        cap_in[i] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 R2: every mapped register reads zero after reset
        for (int a = 0; a < 12; a++) begin
            if (a != 7) begin
                rd(a, v);
                chk("R1 reset register", v, 0);
            end
        end
        chk("R1 irq after reset", {31'd0, irq}, 0);

        // R3: random prescale limits and run lengths
        for (int t = 0; t < 8; t++) begin
            int p = $urandom_range(0, 5);
            int k = $urandom_range(1, 60);
            wr(0, 0);
            wr(2, p);
            restart();
            repeat (k) @(posedge clk);
            #1;
            rd(1, v);
            rd(3, v2);
            chk("R3 count", v, ticks_of(k, p));
            chk("R3 prescale count", v2, k % (p + 1));
        end

        // R5 R6: flag plus zero action on slot 0
        for (int t = 0; t < 6; t++) begin
            int p = $urandom_range(0, 3);
            int m = $urandom_range(2, 20);
            int k = $urandom_range(1, 90);
            int tk;
            wr(0, 0);
            wr(2, p);
            wr(8, m);
            wr(4, 32'b011);
            wr(5, 32'hF);
            restart();
            repeat (k) @(posedge clk);
            #1;
            tk = ticks_of(k, p);
            rd(1, v);
            chk("R6 clear-on-match count", v, cyc_of(tk, m));
            rd(5, v);
            chk("R5 flag 0", v, (tk >= m + 1) ? 1 : 0);
            chk("R8 irq follows flags", {31'd0, irq}, (tk >= m + 1) ? 1 : 0);
        end

        // R7: halt only on slot 1, flag disabled
        begin
            int m = $urandom_range(3, 30);
            wr(0, 0);
            wr(2, 0);
            wr(9, m);
            wr(4, 32'b100 << 3);
            wr(5, 32'hF);
            restart();
            repeat (m - 1) @(posedge clk);
            #1;
            rd(1, v);
            chk("R7 before halt count", v, m - 1);
            rd(0, v);
            chk("R7 before halt ctrl", v, 1);
            repeat (10) @(posedge clk);
            #1;
            rd(1, v);
            chk("R7 halted count", v, m);
            rd(0, v);
            chk("R7 halted ctrl", v, 0);
            rd(5, v);
            chk("R5 no flag without enable", v, 0);
            // halt combined with zero
            wr(4, 32'b110 << 3);
            restart();
            repeat (m + 5) @(posedge clk);
            #1;
            rd(1, v);
            chk("R7 halt with zero count", v, 0);
            rd(0, v);
            chk("R7 halt with zero ctrl", v, 0);
        end

        // R4: wrap with no actions, then with an all-ones compare flagging
        wr(0, 0);
        wr(2, 0);
        wr(4, 0);
        wr(5, 32'hF);
        restart();
        repeat (300) @(posedge clk);
        #1;
        rd(1, v);
        chk("R4 wrap count", v, 300 % 256);
        rd(5, v);
        chk("R4 no flag on wrap", v, 0);
        wr(0, 0);
        wr(10, 255);
        wr(4, 32'b001 << 6);
        restart();
        repeat (250) @(posedge clk);
        #1;
        rd(5, v);
        chk("R4 no flag before wrap", v, 0);
        repeat (11) @(posedge clk);
        #1;
        rd(1, v);
        chk("R4 count after wrap", v, 5);
        rd(5, v);
        chk("R4 all-ones compare flag", v, 4);
        chk("R8 irq high", {31'd0, irq}, 1);

        // R9: idle holds the count
        wr(0, 0);
        rd(1, v);
        repeat (10) @(posedge clk);
        #1;
        rd(1, v2);
        chk("R9 idle holds count", v2, v);

        // R8: write of zero keeps flags, write of one clears
        wr(5, 0);
        rd(5, v);
        chk("R8 zero write keeps flag", v, 4);
        wr(5, 4);
        rd(5, v);
        chk("R8 one write clears flag", v, 0);
        chk("R8 irq low", {31'd0, irq}, 0);

        // R9: clear hold
        wr(0, 2);
        repeat (5) @(posedge clk);
        #1;
        rd(1, v);
        chk("R9 clear holds count", v, 0);
        rd(3, v);
        chk("R9 clear holds prescale", v, 0);
        rd(0, v);
        chk("R9 clear readback", v, 2);

        // R10: edge mode on input 1, pulses on input 0 ignored
        wr(0, 0);
        wr(4, 0);
        wr(2, 3);
        wr(6, 32'b0101);
        restart();
        begin
            int n = $urandom_range(3, 9);
            for (int i = 0; i < n; i++) begin
                pulse(1);
                pulse(0);
            end
            repeat (4) @(posedge clk);
            #1;
            rd(1, v);
            chk("R10 edge count input 1", v, n);
            rd(3, v);
            chk("R10 prescale idle in edge mode", v, 0);
        end
        // R10: input 0 selected
        wr(6, 32'b0001);
        restart();
        for (int i = 0; i < 4; i++) pulse(0);
        pulse(1);
        repeat (4) @(posedge clk);
        #1;
        rd(1, v);
        chk("R10 edge count input 0", v, 4);

        // R11: reserved select codes give no advance
        wr(6, 32'b1001);
        restart();
        pulse(0);
        pulse(1);
        wr(6, 32'b1101);
        pulse(0);
        pulse(1);
        repeat (4) @(posedge clk);
        #1;
        rd(1, v);
        chk("R11 reserved select count", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule